// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a three-wire control port that gives a host access to a small bank of 16-bit configuration registers. It has three lines: an active-low frame enable, a serial clock driven by the host, and one data line that both sides share. All of its logic runs from the serial clock, and there is no free-running clock anywhere in the block. The block's bit counter returns to the start of a frame only on a rising serial-clock edge that it sees while the enable is high. For that reason the host must provide at least one such idle edge before it opens each frame.

Every frame starts with a direction bit followed by a 7-bit register address. In a write frame, 16 data bits follow the address, and the completed word is stored in the addressed register. In a read frame, the slave leaves a gap of one and a half bit periods after the address. It then takes control of the data line and shifts the register contents out, most significant bit first. The shared line is split into input, output and output-enable ports, and the pad's tristate driver sits outside the block. The register contents are presented in parallel on `cfg_o` for the logic that these registers control.

Top module: `sercfg_slave`

## Requirements
- R1: While `sen_ni` is low, the block samples `sdata_i` on each rising edge of `sclk_i`. The first bit of a frame is the direction bit: 1 selects a read and 0 selects a write. The next 7 bits are the register address, most significant bit first.
- R2: In a write frame, 16 data bits follow the address, most significant bit first. On the rising edge that samples the 16th data bit, the word is written to the addressed register. From then on it appears on `cfg_o[16*a +: 16]` for address `a`.
- R3: A write frame that ends (enable raised, then a rising edge) before all 16 data bits have been sampled leaves every register unchanged.
- R4: In a write frame, any bits that arrive after the 16th data bit are ignored. The register keeps the first 16 data bits.
- R5: Addresses `NUM_REGS` and above are not implemented. Writes to them change nothing, and reads from them return 16'h0000.
- R6: In a read frame, the slave drives bit 15 of the register on the falling edge that comes 1.5 bit periods after the rising edge sampling the last address bit. It drives each following bit on the next falling edge. The host samples each bit on the rising edge that follows it.
- R7: `sdata_oe_o` is high only in a read frame, from the falling edge that drives bit 15 until the falling edge after the rising edge that samples bit 0. It is low for the whole of a write frame, and it is low whenever `sen_ni` is high.
- R8: The bit counter is cleared only on a rising `sclk_i` edge seen with `sen_ni` high. If the enable pulses high with no rising edge during the pulse, the frame continues from where it was.
- R9: After `rst_ni` is asserted, every register reads 16'h0000 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| sen_ni | input | 1 | Active-low frame enable |
| sdata_i | input | 1 | Data line as received at the pad |
| sdata_o | output | 1 | Data line value driven by the slave |
| sdata_oe_o | output | 1 | Data line output enable (1 = slave drives) |
| cfg_o | output | 16*NUM_REGS | Register contents, register a at bits 16*a+15 to 16*a |

## Verification
If the bit counter is off by one, the error shows within the same frame, and in one of three ways. A read word comes back shifted by one bit position. The output enable rises on the wrong falling edge. Or a write lands on the rising edge before or after the 16th data bit, so `cfg_o` shows a shifted word or no change at all. If the direction or address state is wrong, the next frame that touches an affected address shows it. A write updates the wrong slice of `cfg_o` as soon as the frame commits, or a read of an unimplemented address comes back nonzero. Sweeping every address on both reads and writes exposes any of these faults within one frame.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 16;
  localparam int HDR_BITS = 1 + ADDR_W;
  localparam int WR_LAST  = HDR_BITS + DATA_W - 1;
  localparam int RD_LOAD  = HDR_BITS + 1;
  localparam int RD_END   = RD_LOAD + DATA_W;
  localparam int CNT_W    = $clog2(RD_END + 1);

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam logic DIR_READ = 1'b1;
endpackage

// File: rtl/sercfg_rx.sv
module sercfg_rx
  import sercfg_pkg::*;
(
  input  logic  rst_ni,
  input  logic  sclk_i,
  input  logic  sen_ni,
  input  logic  sdata_i,
  output cnt_t  cnt_o,
  output logic  dir_o,
  output addr_t addr_o,
  output logic  wr_en_o,
  output word_t wr_data_o
);
  localparam cnt_t HDR_C  = cnt_t'(HDR_BITS);
  localparam cnt_t LAST_C = cnt_t'(WR_LAST);
  localparam cnt_t END_C  = cnt_t'(RD_END);

  cnt_t  cnt_q;
  logic  dir_q;
  addr_t addr_q;
  word_t sr_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      addr_q <= '0;
      sr_q   <= '0;
    end else if (sen_ni) begin
      cnt_q <= '0;
    end else begin
      if (cnt_q != END_C) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) dir_q <= sdata_i;
      else if (cnt_q < HDR_C) addr_q <= {addr_q[ADDR_W-2:0], sdata_i};
      else if (cnt_q <= LAST_C) sr_q <= {sr_q[DATA_W-2:0], sdata_i};
    end
  end

  // commit on the edge sampling the last data bit
  assign wr_en_o   = !sen_ni && (dir_q != DIR_READ) && (cnt_q == LAST_C);
  assign wr_data_o = {sr_q[DATA_W-2:0], sdata_i};
  assign cnt_o     = cnt_q;
  assign dir_o     = dir_q;
  assign addr_o    = addr_q;
endmodule

// File: rtl/sercfg_regfile.sv
module sercfg_regfile
  import sercfg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       wr_en_i,
  input  addr_t                      addr_i,
  input  word_t                      wr_data_i,
  output word_t                      rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  word_t regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge sclk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (wr_en_i && addr_i == addr_t'(g)) regs_q[g] <= wr_data_i;
    end
    assign cfg_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == addr_t'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/sercfg_tx.sv
module sercfg_tx
  import sercfg_pkg::*;
(
  input  logic  rst_ni,
  input  logic  sclk_i,
  input  cnt_t  cnt_i,
  input  logic  dir_i,
  input  word_t rd_data_i,
  output logic  sdo_o,
  output logic  oe_o
);
  localparam cnt_t LOAD_C = cnt_t'(RD_LOAD);
  localparam cnt_t END_C  = cnt_t'(RD_END);

  word_t sr_q;
  logic  oe_q;

  // falling-edge launch gives the 1.5-bit turnaround
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      oe_q <= 1'b0;
    end else if (cnt_i == LOAD_C && dir_i == DIR_READ) begin
      sr_q <= rd_data_i;
      oe_q <= 1'b1;
    end else if (cnt_i == END_C || cnt_i < LOAD_C) begin
      oe_q <= 1'b0;
    end else if (oe_q) begin
      sr_q <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sr_q[DATA_W-1];
  assign oe_o  = oe_q;
endmodule

// File: rtl/sercfg_slave.sv
module sercfg_slave
  import sercfg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       sen_ni,
  input  logic                       sdata_i,
  output logic                       sdata_o,
  output logic                       sdata_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  cnt_t  cnt;
  logic  dir;
  addr_t addr;
  logic  wr_en;
  word_t wr_data;
  word_t rd_data;
  logic  oe_q;

  sercfg_rx u_rx (
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_i),
    .sen_ni   (sen_ni),
    .sdata_i  (sdata_i),
    .cnt_o    (cnt),
    .dir_o    (dir),
    .addr_o   (addr),
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data)
  );

  sercfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_i),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .cfg_o    (cfg_o)
  );

  sercfg_tx u_tx (
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_i),
    .cnt_i    (cnt),
    .dir_i    (dir),
    .rd_data_i(rd_data),
    .sdo_o    (sdata_o),
    .oe_o     (oe_q)
  );

  assign sdata_oe_o = oe_q & ~sen_ni;
endmodule

// File: rtl/sercfg_slave_chk.sv
module sercfg_slave_chk
  import sercfg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                       rst_ni,
  input logic                       sclk_i,
  input logic                       sen_ni,
  input logic                       sdata_i,
  input logic                       sdata_oe_o,
  input logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  cnt_t m_cnt;
  logic m_dir;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= '0;
      m_dir <= 1'b0;
    end else if (sen_ni) begin
      m_cnt <= '0;
    end else begin
      if (m_cnt != cnt_t'(RD_END)) m_cnt <= m_cnt + 1'b1;
      if (m_cnt == '0) m_dir <= sdata_i;
    end
  end

  logic in_rd_win;
  assign in_rd_win = !sen_ni && m_dir && (m_cnt >= cnt_t'(RD_LOAD)) &&
                     (m_cnt < cnt_t'(RD_END));

  p_oe_idle_r7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    sen_ni |-> !sdata_oe_o);

  p_oe_window_r7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    sdata_oe_o |-> in_rd_win);

  p_oe_required_r6: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    in_rd_win |-> sdata_oe_o);

  // R2/R3: registers move only on the 16th write data edge
  p_cfg_hold_r2: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !(!sen_ni && !m_dir && m_cnt == cnt_t'(WR_LAST)) |=> $stable(cfg_o));
endmodule

bind sercfg_slave sercfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .rst_ni    (rst_ni),
  .sclk_i    (sclk_i),
  .sen_ni    (sen_ni),
  .sdata_i   (sdata_i),
  .sdata_oe_o(sdata_oe_o),
  .cfg_o     (cfg_o)
);

// File: tb/sercfg_slave_tb_top.sv
module sercfg_slave_tb_top;
  localparam int NR    = 8;
  localparam int CFG_W = NR * 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sen_ni = 1'b1;
  logic sdata_i = 1'b0;
  logic sdata_o;
  logic sdata_oe_o;
  logic [CFG_W-1:0] cfg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [CFG_W-1:0] exp_cfg = '0;

  always #4 clk = ~clk;

  sercfg_slave #(.NUM_REGS(NR)) dut_i (
    .rst_ni(rst_ni), .sclk_i(clk), .sen_ni(sen_ni), .sdata_i(sdata_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .cfg_o(cfg_o)
  );

  task automatic chk(input string req, input logic [CFG_W-1:0] act,
                     input logic [CFG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'((i + 1) * 16'h3B1D + 16'h0F0F);
  endfunction

  // glitch_after: pulse enable high (no rising edge) after this many data bits
  task automatic write_frame(input logic [6:0] a, input logic [15:0] d,
                             input int nbits, input int extra, input int glitch_after);
    bit oe_seen = 0;
    sen_ni = 1'b0;
    sdata_i = 1'b0;
    for (int i = 6; i >= 0; i--) begin
      step(); oe_seen |= sdata_oe_o; sdata_i = a[i];
    end
    for (int k = 0; k < nbits; k++) begin
      step(); oe_seen |= sdata_oe_o; sdata_i = d[15-k];
      if (k + 1 == glitch_after) begin
        #1 sen_ni = 1'b1;
        #2 sen_ni = 1'b0;
      end
    end
    for (int k = 0; k < extra; k++) begin
      step(); oe_seen |= sdata_oe_o; sdata_i = 1'b1;
    end
    step(); oe_seen |= sdata_oe_o;
    sen_ni = 1'b1;
    step();
    chk("R7 no drive during write", CFG_W'(oe_seen), CFG_W'(0));
  endtask

  task automatic read_frame(input logic [6:0] a, input logic [15:0] exp);
    logic [15:0] word = '0;
    bit oe_lost = 0;
    sen_ni = 1'b0;
    sdata_i = 1'b1;
    for (int i = 6; i >= 0; i--) begin
      step(); sdata_i = a[i];
    end
    step(); sdata_i = 1'b0;
    step();
    chk("R6 turnaround gap", CFG_W'(sdata_oe_o), CFG_W'(0));
    for (int b = 15; b >= 0; b--) begin
      step();
      word[b] = sdata_o;
      if (sdata_oe_o !== 1'b1) oe_lost = 1;
    end
    chk("R7 drive through data phase", CFG_W'(oe_lost), CFG_W'(0));
    chk("R6 read word", CFG_W'(word), CFG_W'(exp));
    step();
    chk("R7 release after bit 0", CFG_W'(sdata_oe_o), CFG_W'(0));
    sen_ni = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R9 reset cfg", cfg_o, '0);
    chk("R9 reset line released", CFG_W'(sdata_oe_o), CFG_W'(0));
    rst_ni = 1'b1;
    step();
    read_frame(7'd3, 16'h0000); // R9

    // R1 R2: fill every register
    for (int r = 0; r < NR; r++) begin
      write_frame(7'(r), pat(r), 16, 0, -1);
      exp_cfg[r*16 +: 16] = pat(r);
      chk("R2 write commit", cfg_o, exp_cfg);
    end

    // R5 R6: full address sweep on reads
    for (int a = 0; a < 128; a++)
      read_frame(7'(a), (a < NR) ? pat(a) : 16'h0000);

    // R5: writes above the bank touch nothing
    for (int a = NR; a < 128; a++) begin
      write_frame(7'(a), 16'hFFFF, 16, 0, -1);
      chk("R5 unimplemented write", cfg_o, exp_cfg);
    end

    // R3: every short length discarded
    for (int n = 0; n < 16; n++) begin
      write_frame(7'd2, ~pat(2), n, 0, -1);
      chk("R3 short frame", cfg_o, exp_cfg);
    end

    // R4: trailing bits ignored
    write_frame(7'd5, 16'h1234, 16, 5, -1);
    exp_cfg[5*16 +: 16] = 16'h1234;
    chk("R4 extra bits", cfg_o, exp_cfg);

    // R8: enable pulse without a rising edge keeps the frame alive
    write_frame(7'd6, 16'hC0DE, 16, 0, 8);
    exp_cfg[6*16 +: 16] = 16'hC0DE;
    chk("R8 no edge no restart", cfg_o, exp_cfg);
    read_frame(7'd6, 16'hC0DE);

    // R7: abort a read mid-word
    sen_ni = 1'b0;
    sdata_i = 1'b1;
    for (int i = 6; i >= 0; i--) begin
      step(); sdata_i = 1'(7'd1 >> i);
    end
    repeat (6) step();
    sen_ni = 1'b1;
    #1;
    chk("R7 released on enable high", CFG_W'(sdata_oe_o), CFG_W'(0));
    step();
    read_frame(7'd1, pat(1));
    chk("R1 bank intact", cfg_o, exp_cfg);

    finish_run();
  end
endmodule